// File: doc/BRIEF.md
# Configurable Output Logic Macrocell Array

This block is a small programmable sum-of-products fabric whose every output passes through a configurable output cell. Each cell ORs a fixed number of programmable product terms. A static configuration word picks whether the pin sees that sum directly or a copy of it held in a D flip-flop. The word also picks whether the result is inverted on its way out. The pin driver is tri-state. Its enable is one more product term of the same array, dedicated to that cell, and is not a plain port.

Every cell sends a feedback bit back into the product-term array, where every term of every cell can use it as a literal. In registered mode the feedback is the flip-flop state, so a few cells can hold the state of a counter or state machine and compute their own next state. In combinational mode the feedback is the value on the pin: the driven value when the driver is on, and the externally applied value when it is off. One cell can therefore form a partial sum that a second cell extends past its own term budget.

The pin is modelled as three plain signals: the drive value, the drive enable and the sampled pad value. The product-term masks, term enables and cell modes are static inputs, held by whatever programs the array.

Top module: `olmc_array`

## Requirements
- R1: With `cfg_reg[c]`=0, `pin_out[c]` follows the OR of the cell's enabled product terms in the same cycle, with no clock edge needed.
- R2: With `cfg_reg[c]`=1, the cell's flip-flop takes the OR-sum on each rising clock edge. `pin_out[c]` shows only the captured value and holds it between edges while the inputs change.
- R3: `cfg_inv[c]`=1 inverts `pin_out[c]` relative to the selected combinational or registered value, in both modes. `cfg_inv[c]`=0 passes the value unchanged.
- R4: `pin_oe[c]` equals the cell's dedicated enable product term, built from `oe_true`/`oe_comp` bits `c*W+k`. A term with no literals selected is 1, so the driver is always on.
- R5: In registered mode `fb[c]` is the flip-flop state, before inversion. In combinational mode `fb[c]` is `pin_out[c]` when `pin_oe[c]` is 1 and `pin_in[c]` when it is 0.
- R6: The array input vector has W = N_IN + N_CELLS bits. Bit k < N_IN is `in_sig[k]`, and bit N_IN+j is `fb[j]`. Term t of cell c uses mask bits `(c*TERMS+t)*W+k`. A set `and_true` bit requires that input to be 1, and a set `and_comp` bit requires it to be 0. A term with both bits set on one input is always 0, and a term with no bits set is 1.
- R7: A product term whose `term_en[c*TERMS+t]` bit is 0 adds nothing to the sum. With all of a cell's terms disabled, its sum is 0.
- R8: A function that needs more than TERMS product terms can be built by feeding one combinational cell's partial sum into another cell through feedback.
- R9: A synchronous `rst` clears every flip-flop to 0. During and right after reset, a registered cell shows `fb`=0 and `pin_out`=`cfg_inv`.
- R10: Registered cells that use their own feedback step through a sequence, one state per clock edge. For example, two cells programmed as a 2-bit binary counter go 0,1,2,3,0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Global clock shared by all cell flip-flops |
| rst | input | 1 | Synchronous active-high reset of the flip-flops |
| in_sig | input | N_IN | Dedicated array inputs |
| pin_in | input | N_CELLS | Sampled value present on each pin |
| cfg_reg | input | N_CELLS | Per-cell mode: 0 combinational, 1 registered |
| cfg_inv | input | N_CELLS | Per-cell polarity: 0 true, 1 inverted |
| term_en | input | N_CELLS*TERMS | Per-term enable into the cell OR |
| and_true | input | N_CELLS*TERMS*W | Per-term true-literal select mask |
| and_comp | input | N_CELLS*TERMS*W | Per-term complement-literal select mask |
| oe_true | input | N_CELLS*W | Enable-term true-literal select mask |
| oe_comp | input | N_CELLS*W | Enable-term complement-literal select mask |
| pin_out | output | N_CELLS | Value driven toward each pin |
| pin_oe | output | N_CELLS | Drive enable per pin (0 = high impedance) |
| fb | output | N_CELLS | Feedback bit per cell, also an array input |

## Verification
The hardest case to reach is the one where feedback must carry meaning. Either a registered cell's next state depends on its own state, or a combinational cell's feedback switches between its own drive and the outside pin value as its enable term changes. The bench programs two registered cells as a counter and checks several full wraps from reset. It then ties a combinational cell's enable to an input bit and sweeps that bit against both pin values. A third program spreads a six-term majority function over two chained cells and sweeps all sixteen input patterns.

// File: rtl/olmc_pkg.sv
package olmc_pkg;
  typedef enum logic {
    OUT_COMB = 1'b0,
    OUT_REG  = 1'b1
  } out_mode_e;

  typedef struct packed {
    out_mode_e mode;
    logic      invert;
  } cell_cfg_t;
endpackage

// File: rtl/olmc_pterm.sv
// One programmable AND term over the shared array input vector.
module olmc_pterm #(
  parameter int W = 6
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] lit_true,
  input  logic [W-1:0] lit_comp,
  output logic         term
);
  // Unselected inputs pass 1; a selected input must match its literal.
  assign term = &((x | ~lit_true) & (~x | ~lit_comp));
endmodule

// File: rtl/olmc_cell.sv
// Output cell: OR of terms, optional register, polarity, enable, feedback.
module olmc_cell
  import olmc_pkg::*;
#(
  parameter int   TERMS        = 4,
  parameter logic FF_RESET_VAL = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  cell_cfg_t        cfg,
  input  logic [TERMS-1:0] terms,
  input  logic [TERMS-1:0] term_en,
  input  logic             oe_term,
  input  logic             pin_in,
  output logic             pin_out,
  output logic             pin_oe,
  output logic             fb,
  output logic             or_sum
);
  logic state_q;
  logic sel_val;

  assign or_sum = |(terms & term_en);

  always_ff @(posedge clk) begin
    if (rst) state_q <= FF_RESET_VAL;
    else     state_q <= or_sum;
  end

  // Polarity applies after the mode selector, so both paths can invert.
  assign sel_val = (cfg.mode == OUT_REG) ? state_q : or_sum;
  assign pin_out = sel_val ^ cfg.invert;
  assign pin_oe  = oe_term;
  assign fb      = (cfg.mode == OUT_REG) ? state_q
                                         : (oe_term ? pin_out : pin_in);
endmodule

// File: rtl/olmc_array.sv
// Small AND-OR array whose outputs pass through configurable cells.
module olmc_array
  import olmc_pkg::*;
#(
  parameter int   N_IN         = 4,
  parameter int   N_CELLS      = 2,
  parameter int   TERMS        = 4,
  parameter logic FF_RESET_VAL = 1'b0
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic [N_IN-1:0]                        in_sig,
  input  logic [N_CELLS-1:0]                     pin_in,
  input  logic [N_CELLS-1:0]                     cfg_reg,
  input  logic [N_CELLS-1:0]                     cfg_inv,
  input  logic [N_CELLS*TERMS-1:0]               term_en,
  input  logic [N_CELLS*TERMS*(N_IN+N_CELLS)-1:0] and_true,
  input  logic [N_CELLS*TERMS*(N_IN+N_CELLS)-1:0] and_comp,
  input  logic [N_CELLS*(N_IN+N_CELLS)-1:0]       oe_true,
  input  logic [N_CELLS*(N_IN+N_CELLS)-1:0]       oe_comp,
  output logic [N_CELLS-1:0]                     pin_out,
  output logic [N_CELLS-1:0]                     pin_oe,
  output logic [N_CELLS-1:0]                     fb
);
  localparam int W = N_IN + N_CELLS;

  logic [W-1:0]       arr_x;
  logic [N_CELLS-1:0] or_sum;

  assign arr_x = {fb, in_sig};

  for (genvar c = 0; c < N_CELLS; c++) begin : g_cell
    logic [TERMS-1:0] cell_terms;
    logic             cell_oe;
    cell_cfg_t        cell_cfg;

    for (genvar t = 0; t < TERMS; t++) begin : g_term
      olmc_pterm #(.W(W)) u_term (
        .x        (arr_x),
        .lit_true (and_true[(c*TERMS+t)*W +: W]),
        .lit_comp (and_comp[(c*TERMS+t)*W +: W]),
        .term     (cell_terms[t])
      );
    end

    olmc_pterm #(.W(W)) u_oe_term (
      .x        (arr_x),
      .lit_true (oe_true[c*W +: W]),
      .lit_comp (oe_comp[c*W +: W]),
      .term     (cell_oe)
    );

    assign cell_cfg.mode   = out_mode_e'(cfg_reg[c]);
    assign cell_cfg.invert = cfg_inv[c];

    olmc_cell #(.TERMS(TERMS), .FF_RESET_VAL(FF_RESET_VAL)) u_cell (
      .clk     (clk),
      .rst     (rst),
      .cfg     (cell_cfg),
      .terms   (cell_terms),
      .term_en (term_en[c*TERMS +: TERMS]),
      .oe_term (cell_oe),
      .pin_in  (pin_in[c]),
      .pin_out (pin_out[c]),
      .pin_oe  (pin_oe[c]),
      .fb      (fb[c]),
      .or_sum  (or_sum[c])
    );
  end
endmodule

// File: rtl/olmc_array_chk.sv
module olmc_array_chk #(
  parameter int N_CELLS = 2,
  parameter int TERMS   = 4
) (
  input logic                     clk,
  input logic                     rst,
  input logic [N_CELLS-1:0]       cfg_reg,
  input logic [N_CELLS-1:0]       cfg_inv,
  input logic [N_CELLS*TERMS-1:0] term_en,
  input logic [N_CELLS-1:0]       pin_in,
  input logic [N_CELLS-1:0]       pin_out,
  input logic [N_CELLS-1:0]       pin_oe,
  input logic [N_CELLS-1:0]       fb,
  input logic [N_CELLS-1:0]       or_sum
);
  for (genvar c = 0; c < N_CELLS; c++) begin : g_chk
    // R2
    reg_capture_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(!rst) && cfg_reg[c] && $past(cfg_reg[c])) |-> (fb[c] == $past(or_sum[c])));

    // R1 R3
    polarity_chk: assert property (@(posedge clk) disable iff (rst)
      pin_out[c] == ((cfg_reg[c] ? fb[c] : or_sum[c]) ^ cfg_inv[c]));

    // R5
    comb_feedback_chk: assert property (@(posedge clk) disable iff (rst)
      !cfg_reg[c] |-> (fb[c] == (pin_oe[c] ? pin_out[c] : pin_in[c])));

    // R7
    empty_sum_chk: assert property (@(posedge clk) disable iff (rst)
      (term_en[c*TERMS +: TERMS] == '0) |-> !or_sum[c]);

    // R9
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(rst) && cfg_reg[c]) |-> (fb[c] == 1'b0));
  end
endmodule

bind olmc_array olmc_array_chk #(.N_CELLS(N_CELLS), .TERMS(TERMS)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .cfg_reg (cfg_reg),
  .cfg_inv (cfg_inv),
  .term_en (term_en),
  .pin_in  (pin_in),
  .pin_out (pin_out),
  .pin_oe  (pin_oe),
  .fb      (fb),
  .or_sum  (or_sum)
);

// File: tb/olmc_array_bench.sv
module olmc_array_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N_IN    = 4;
  localparam int N_CELLS = 2;
  localparam int TERMS   = 4;
  localparam int W       = N_IN + N_CELLS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N_IN-1:0]              in_sig  = '0;
  logic [N_CELLS-1:0]           pin_in  = '0;
  logic [N_CELLS-1:0]           cfg_reg = '0;
  logic [N_CELLS-1:0]           cfg_inv = '0;
  logic [N_CELLS*TERMS-1:0]     term_en = '0;
  logic [N_CELLS*TERMS*W-1:0]   and_true = '0;
  logic [N_CELLS*TERMS*W-1:0]   and_comp = '0;
  logic [N_CELLS*W-1:0]         oe_true = '0;
  logic [N_CELLS*W-1:0]         oe_comp = '0;
  logic [N_CELLS-1:0]           pin_out;
  logic [N_CELLS-1:0]           pin_oe;
  logic [N_CELLS-1:0]           fb;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  olmc_array #(.N_IN(N_IN), .N_CELLS(N_CELLS), .TERMS(TERMS)) u_olmc_array (
    .clk(clk), .rst(rst), .in_sig(in_sig), .pin_in(pin_in),
    .cfg_reg(cfg_reg), .cfg_inv(cfg_inv), .term_en(term_en),
    .and_true(and_true), .and_comp(and_comp),
    .oe_true(oe_true), .oe_comp(oe_comp),
    .pin_out(pin_out), .pin_oe(pin_oe), .fb(fb)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_prog();
    term_en = '0; and_true = '0; and_comp = '0;
    oe_true = '0; oe_comp = '0; cfg_reg = '0; cfg_inv = '0;
  endtask

  task automatic set_term(input int c, input int t,
                          input logic [W-1:0] tm, input logic [W-1:0] cm);
    term_en[c*TERMS+t] = 1'b1;
    and_true[(c*TERMS+t)*W +: W] = tm;
    and_comp[(c*TERMS+t)*W +: W] = cm;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int ones;
    int exp_v;
    // R9: reset state of a registered cell, both polarities
    clear_prog();
    cfg_reg = 2'b11; cfg_inv = 2'b10;
    repeat (2) @(posedge clk);
    settle();
    chk("R9 fb during reset", fb, 0);
    chk("R9 pin_out during reset", pin_out, 2'b10);
    rst = 1'b0;
    #1;
    chk("R9 fb right after reset", fb, 0);

    // R1 R3 R6: combinational sum in0&~in1 | in2&in3, both polarities
    clear_prog();
    set_term(0, 0, 6'b000001, 6'b000010);
    set_term(0, 1, 6'b001100, 6'b000000);
    for (int inv = 0; inv < 2; inv++) begin
      for (int v = 0; v < 16; v++) begin
        settle();
        cfg_inv[0] = inv[0];
        in_sig = v[3:0];
        #1;
        exp_v = ((((v & 1) != 0) && ((v & 2) == 0)) || ((v & 12) == 12)) ? 1 : 0;
        chk("R1 R3 comb sum", pin_out[0], exp_v ^ inv);
      end
    end

    // R6: contradictory literals give 0, empty term gives 1
    clear_prog();
    set_term(0, 0, 6'b000001, 6'b000001);
    for (int v = 0; v < 16; v++) begin
      settle(); in_sig = v[3:0]; #1;
      chk("R6 contradictory term", pin_out[0], 0);
    end
    clear_prog();
    set_term(0, 2, 6'b000000, 6'b000000);
    settle(); in_sig = 4'h5; #1;
    chk("R6 empty term", pin_out[0], 1);

    // R7: all terms disabled gives sum 0 (seen inverted as 1)
    clear_prog();
    and_true = '1;
    cfg_inv = 2'b11;
    settle(); in_sig = 4'hF; #1;
    chk("R7 disabled terms", pin_out, 2'b11);

    // R4: enable term of cell 0 is in3, cell 1 enable empty
    clear_prog();
    oe_true[0*W +: W] = 6'b001000;
    for (int v = 0; v < 16; v++) begin
      settle(); in_sig = v[3:0]; #1;
      chk("R4 enable term", pin_oe[0], (v >> 3) & 1);
      chk("R4 empty enable", pin_oe[1], 1);
    end

    // R5: comb feedback follows drive when enabled, pin when not
    clear_prog();
    set_term(0, 0, 6'b000001, 6'b000000);
    oe_true[0*W +: W] = 6'b001000;
    cfg_inv[0] = 1'b1;
    for (int v = 0; v < 16; v++) begin
      for (int p = 0; p < 2; p++) begin
        settle(); in_sig = v[3:0]; pin_in[0] = p[0]; #1;
        exp_v = ((v >> 3) & 1) != 0 ? ((v & 1) ^ 1) : p;
        chk("R5 comb feedback", fb[0], exp_v);
      end
    end

    // R8: majority-of-two over 4 inputs split across two cells
    clear_prog();
    set_term(0, 0, 6'b000011, 6'b0);
    set_term(0, 1, 6'b000101, 6'b0);
    set_term(0, 2, 6'b001001, 6'b0);
    set_term(0, 3, 6'b000110, 6'b0);
    set_term(1, 0, 6'b010000, 6'b0);
    set_term(1, 1, 6'b001010, 6'b0);
    set_term(1, 2, 6'b001100, 6'b0);
    for (int v = 0; v < 16; v++) begin
      settle(); in_sig = v[3:0]; #1;
      ones = (v & 1) + ((v >> 1) & 1) + ((v >> 2) & 1) + ((v >> 3) & 1);
      chk("R8 chained sum", pin_out[1], (ones >= 2) ? 1 : 0);
    end

    // R2: registered cell holds between edges, updates on edge
    clear_prog();
    set_term(0, 0, 6'b000001, 6'b0);
    cfg_reg[0] = 1'b1;
    settle(); rst = 1'b1; in_sig = 4'h0;
    @(posedge clk); settle(); rst = 1'b0;
    in_sig = 4'h1; #1;
    chk("R2 holds before edge", pin_out[0], 0);
    settle(); #1;
    chk("R2 captured on edge", pin_out[0], 1);
    in_sig = 4'h0; #1;
    chk("R2 holds after input drop", pin_out[0], 1);
    cfg_inv[0] = 1'b1; #1;
    chk("R3 registered inverted", pin_out[0], 0);
    settle(); #1;
    chk("R2 second capture", pin_out[0], 1);
    chk("R5 registered feedback", fb[0], 0);

    // R10: two-bit counter from registered feedback
    clear_prog();
    cfg_reg = 2'b11; cfg_inv = 2'b10;
    set_term(0, 0, 6'b000000, 6'b010000);
    set_term(1, 0, 6'b100000, 6'b010000);
    set_term(1, 1, 6'b010000, 6'b100000);
    settle(); rst = 1'b1;
    @(posedge clk); settle();
    chk("R9 counter reset", fb, 0);
    rst = 1'b0;
    for (int k = 1; k <= 9; k++) begin
      settle(); #1;
      chk("R10 counter state", fb, k % 4);
      chk("R10 counter pins", pin_out, (k % 4) ^ 2);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule